// File: doc/BRIEF.md
# Binary Early/Late Phase Detector

This block is the decision stage of a clock-and-data-recovery loop. It sees the serial stream as one oversample per clock, together with an index telling which of the recovered clock's sub-phases that oversample belongs to. Whenever the stream goes from 0 to 1, the block decides whether the edge arrived ahead of the recovered clock's falling-edge phase or at/after it. It presents that verdict as a single registered up/down bit for a downstream loop filter, and it pulses a one-cycle strobe on every refresh.

The verdict has only two values: there is no neutral or hold level. Between rising edges the bit simply keeps its last value. This makes the correction the loop receives per unit time independent of how dense the transitions are. The block also returns the retimed data bit: the oversample taken at the mid-eye phase, half a unit interval after the falling-edge phase.

The oversampling ratio is `2**PHASE_W`. The falling-edge phase is `FALL_IDX`. The sampling phase is `(FALL_IDX + 2**(PHASE_W-1)) mod 2**PHASE_W`.

Top module: `bbpd_top`

## Requirements
- R1: While reset is low and after its release, before any sample has been captured, `earlyLate`, `decisionValid` and `retimedData` are all 0.
- R2: A rising transition is captured when `sampleIn` is 1 at a clock edge and the previously captured sample was 0. For such a transition, let the offset be `(phaseIdx - FALL_IDX) mod 2**PHASE_W`. If the offset is at least `2**(PHASE_W-1)` (a negative signed offset, meaning early), `earlyLate` is 1 from that edge onward.
- R3: For a captured rising transition with an offset below `2**(PHASE_W-1)` (zero or positive, meaning late), `earlyLate` is 0 from that edge onward.
- R4: `decisionValid` is 1 for exactly the one cycle after each edge that captures a rising transition, and 0 in all other cycles.
- R5: A falling transition (1 then 0) or an unchanged sample leaves `earlyLate` unchanged and `decisionValid` at 0. The output never takes a third level.
- R6: At an edge where `phaseIdx` equals the sampling phase `(FALL_IDX + 2**(PHASE_W-1)) mod 2**PHASE_W`, `retimedData` takes `sampleIn`. At every other edge it holds.
- R7: A held decision persists for any number of cycles without rising transitions, and each new verdict depends only on the phase of its own transition, whether transitions are dense or sparse.
- R8: The previous-sample reference is 0 out of reset, so a 1 in the first captured sample counts as a rising transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, one sample per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleIn | input | 1 | Current oversample of the serial stream |
| phaseIdx | input | PHASE_W | Recovered-clock sub-phase of the current oversample |
| earlyLate | output | 1 | Held verdict: 1 early, 0 late |
| decisionValid | output | 1 | One-cycle strobe on each verdict refresh |
| retimedData | output | 1 | Data bit taken at the mid-eye phase |

## Verification
Every result has one register on its path. A sample and phase presented before a rising clock edge therefore show up on `earlyLate`, `decisionValid` and `retimedData` just after that same edge. The bench drives each stimulus shortly after an edge, waits for the next edge, and compares all three outputs a fixed 1 ns later, well clear of either edge. Its reference model advances in lockstep, one step per edge. The sweep covers every phase index with every pair of consecutive sample values, followed by long sparse stretches and dense alternating stretches to exercise the hold behaviour.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;

  // Strobes from the decision logic to the register stage.
  typedef struct packed {
    logic refresh;  // rising transition seen this cycle
    logic early;    // verdict for that transition
    logic capture;  // current phase is the mid-eye sampling phase
  } bbpdStrobes_t;

endpackage

// File: rtl/bbpd_control.sv
module bbpd_control
  import bbpd_pkg::*;
#(
  parameter int PHASE_W  = 3,
  parameter int FALL_IDX = 0
) (
  input  logic               sampleIn,
  input  logic               prevSample,
  input  logic [PHASE_W-1:0] phaseIdx,
  output bbpdStrobes_t       strobes
);

  localparam int OSR      = 1 << PHASE_W;
  localparam int RISE_IDX = (FALL_IDX + OSR / 2) % OSR;
  localparam logic [PHASE_W-1:0] FALL_REF = PHASE_W'(FALL_IDX);
  localparam logic [PHASE_W-1:0] RISE_REF = PHASE_W'(RISE_IDX);

  logic [PHASE_W-1:0] phaseOffset;
  logic               risingEdge;

  // Modular difference; its top bit is the sign of the wrapped offset.
  assign phaseOffset = phaseIdx - FALL_REF;
  assign risingEdge  = sampleIn & ~prevSample;

  always_comb begin
    strobes.refresh = risingEdge;
    strobes.early   = phaseOffset[PHASE_W-1];
    strobes.capture = (phaseIdx == RISE_REF);
  end

endmodule

// File: rtl/bbpd_datapath.sv
module bbpd_datapath
  import bbpd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sampleIn,
  input  bbpdStrobes_t strobes,
  output logic         prevSample,
  output logic         earlyLate,
  output logic         decisionValid,
  output logic         retimedData
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevSample    <= 1'b0;
      earlyLate     <= 1'b0;
      decisionValid <= 1'b0;
      retimedData   <= 1'b0;
    end else begin
      prevSample    <= sampleIn;
      decisionValid <= strobes.refresh;
      if (strobes.refresh) earlyLate   <= strobes.early;
      if (strobes.capture) retimedData <= sampleIn;
    end
  end

endmodule

// File: rtl/bbpd_top.sv
module bbpd_top
  import bbpd_pkg::*;
#(
  parameter int PHASE_W  = 3,
  parameter int FALL_IDX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sampleIn,
  input  logic [PHASE_W-1:0] phaseIdx,
  output logic               earlyLate,
  output logic               decisionValid,
  output logic               retimedData
);

  bbpdStrobes_t strobes;
  logic         prevSample;

  bbpd_control #(.PHASE_W(PHASE_W), .FALL_IDX(FALL_IDX)) i_control (
    .sampleIn   (sampleIn),
    .prevSample (prevSample),
    .phaseIdx   (phaseIdx),
    .strobes    (strobes)
  );

  bbpd_datapath i_datapath (
    .clk           (clk),
    .rst_n         (rst_n),
    .sampleIn      (sampleIn),
    .strobes       (strobes),
    .prevSample    (prevSample),
    .earlyLate     (earlyLate),
    .decisionValid (decisionValid),
    .retimedData   (retimedData)
  );

endmodule

// File: rtl/bbpd_checker.sv
module bbpd_checker #(
  parameter int PHASE_W  = 3,
  parameter int FALL_IDX = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sampleIn,
  input logic [PHASE_W-1:0] phaseIdx,
  input logic               earlyLate,
  input logic               decisionValid,
  input logic               retimedData
);

  localparam int OSR = 1 << PHASE_W;
  localparam logic [PHASE_W-1:0] MID_REF  = PHASE_W'((FALL_IDX + OSR / 2) % OSR);
  localparam logic [PHASE_W-1:0] FALL_REF = PHASE_W'(FALL_IDX);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!earlyLate && !decisionValid && !retimedData));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && decisionValid) |=> !decisionValid);

  assert_strobe_needs_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && decisionValid) |-> $past(sampleIn));

  assert_verdict_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && decisionValid) |->
      (earlyLate == (($past(phaseIdx) - FALL_REF) >= PHASE_W'(OSR / 2))));

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !decisionValid) |-> $stable(earlyLate));

  assert_retime_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(phaseIdx) == MID_REF) |-> (retimedData == $past(sampleIn)));

  assert_retime_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(phaseIdx) != MID_REF) |-> $stable(retimedData));

endmodule

bind bbpd_top bbpd_checker #(.PHASE_W(PHASE_W), .FALL_IDX(FALL_IDX)) i_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .sampleIn      (sampleIn),
  .phaseIdx      (phaseIdx),
  .earlyLate     (earlyLate),
  .decisionValid (decisionValid),
  .retimedData   (retimedData)
);

// File: tb/test_bbpd_top.sv
`timescale 1ns/1ps
module test_bbpd_top;

  localparam int PHASE_W  = 3;
  localparam int FALL_IDX = 0;
  localparam int OSR      = 1 << PHASE_W;
  localparam int MID_IDX  = (FALL_IDX + OSR / 2) % OSR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sampleIn = 1'b0;
  logic [PHASE_W-1:0] phaseIdx = '0;
  logic earlyLate, decisionValid, retimedData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Reference model state
  int mPrev = 0, mEarly = 0, mRet = 0;

  always #2.5 clk = ~clk;

  bbpd_top #(.PHASE_W(PHASE_W), .FALL_IDX(FALL_IDX)) i_bbpd_top (
    .clk(clk), .rst_n(rst_n), .sampleIn(sampleIn), .phaseIdx(phaseIdx),
    .earlyLate(earlyLate), .decisionValid(decisionValid), .retimedData(retimedData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int verdictOf(input int p);
    int off = (p - FALL_IDX + OSR) % OSR;
    return (off >= OSR / 2) ? 1 : 0;
  endfunction

  // Drive one sample, wait for the capturing edge, compare 1 ns after it.
  task automatic step(input int s, input int p);
    int rising;
    sampleIn = s[0];
    phaseIdx = PHASE_W'(p);
    @(posedge clk);
    #1;
    rising = (mPrev == 0 && s == 1) ? 1 : 0;
    if (rising == 1) mEarly = verdictOf(p);
    if (p == MID_IDX) mRet = s;
    mPrev = s;
    check(decisionValid == rising[0], "R4 decisionValid", decisionValid, rising);
    if (rising == 1)
      check(earlyLate == mEarly[0], mEarly == 1 ? "R2 early verdict" : "R3 late verdict",
            earlyLate, mEarly);
    else
      check(earlyLate == mEarly[0], "R5 hold without rise", earlyLate, mEarly);
    check(retimedData == mRet[0], "R6 retimed data", retimedData, mRet);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!earlyLate && !decisionValid && !retimedData, "R1 reset state",
          {earlyLate, decisionValid, retimedData}, 0);
    rst_n = 1'b1;
    // R8: first captured 1 counts as a rising transition (phase 5 -> early)
    step(1, 5);
    check(decisionValid == 1'b1, "R8 first sample rise", decisionValid, 1);
    step(1, 6);
    step(0, 7);

    // Exhaustive sweep: every phase with every pair of consecutive samples
    for (int p = 0; p < OSR; p++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++) begin
          step(a, (p + 3) % OSR);
          step(b, p);
        end

    // R7: sparse transitions, long holds after an early then a late verdict
    step(0, 1);
    step(1, 6);
    for (int i = 0; i < 40; i++) step(1, i % OSR);
    check(earlyLate == 1'b1, "R7 early held sparse", earlyLate, 1);
    step(0, 0);
    for (int i = 0; i < 25; i++) step(0, (i * 3) % OSR);
    step(1, 2);
    for (int i = 0; i < 40; i++) step(1, (i * 5) % OSR);
    check(earlyLate == 1'b0, "R7 late held sparse", earlyLate, 0);

    // R7: dense alternation, verdict follows each transition's own phase
    for (int i = 0; i < 64; i++) step(i % 2, (i * 7 + 1) % OSR);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule